// File: doc/BRIEF.md
# Binary-Tree Carry-Lookahead Adder

A purely combinational adder of parameterised width `N` (a power of two, default 16). Each bit position forms a generate signal (both operand bits set) and a propagate signal (operand bits differ). A recursive binary tree of lookahead nodes carries this information in two directions. On the way up, each node merges the generate/propagate pairs of its two halves into one pair for the whole block. On the way down, it splits the carry that enters the block into a carry for the lower half and a carry for the upper half. The tree therefore holds exactly `N-1` nodes, and both the upward path and the downward path have depth log2(N).

Each sum bit is the bit's propagate XOR the carry that the tree delivers to that bit. The bit cells have no carry-out logic of their own. The root's generate and propagate are brought out, so a wider structure can use this adder as one block. A finished carry-out is also provided, formed from the root pair and the carry-in.

Top module: `cla_tree_adder`

## Requirements
- R1: `sum_o` equals `(a_i + b_i + c0_i) mod 2^N` for every operand pair and both carry-in values.
- R2: `carry_o` equals bit `N` of the full-width sum `a_i + b_i + c0_i`.
- R3: `g_o` is 1 exactly when `a_i + b_i` is at least `2^N`, that is, when the block produces a carry-out without any carry-in.
- R4: `p_o` is 1 exactly when every bit of `a_i ^ b_i` is 1.
- R5: `carry_o` always equals `g_o | (p_o & c0_i)`, and `g_o` and `p_o` are never 1 together.
- R6: All-propagate operands (`a_i ^ b_i` all ones) with `c0_i = 1` produce `sum_o = 0` and `carry_o = 1`, because the carry crosses every level of the tree.
- R7: All-generate operands (`a_i = b_i` = all ones) produce `carry_o = 1` for both carry-in values, and `sum_o` bit 0 equals `c0_i`, because the low half receives the incoming carry unchanged.
- R8: `N` must be a power of two and at least 2. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| c0_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| g_o | output | 1 | Root block generate |
| p_o | output | 1 | Root block propagate |
| carry_o | output | 1 | Carry out of bit N-1 |

## Verification
The case that matters is a carry that starts at bit 0 and must travel across the top-level split while the root also forms the carry-out in the same evaluation. The bench provokes this with all-propagate operands and a carry-in of 1. It also provokes a generate in a low half that is propagated through a high half, which happens throughout the exhaustive sweep of a 4-bit instance. Every result is judged against the arithmetic sum `a + b + c0` computed at full width in the bench. The root generate and propagate are judged against the sum with no carry-in and against the XOR of the operands.

// File: rtl/cla_pkg.sv
package cla_pkg;
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  function automatic bit is_pow2(int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell (
  input  logic a_i,
  input  logic b_i,
  output cla_pkg::gp_t gp_o
);
  assign gp_o.g = a_i & b_i;
  assign gp_o.p = a_i ^ b_i;  // xor so the sum can reuse it
endmodule

// File: rtl/cla_node.sv
module cla_node (
  input  cla_pkg::gp_t lo_i,
  input  cla_pkg::gp_t hi_i,
  input  logic         c_i,
  output cla_pkg::gp_t blk_o,
  output logic         c_hi_o
);
  assign blk_o.g = hi_i.g | (lo_i.g & hi_i.p);
  assign blk_o.p = hi_i.p & lo_i.p;
  assign c_hi_o  = lo_i.g | (lo_i.p & c_i);
endmodule

// File: rtl/cla_tree.sv
module cla_tree #(
  parameter int W = 16
) (
  input  cla_pkg::gp_t [W-1:0] gp_i,
  input  logic                 c_i,
  output logic [W-1:0]         c_o,
  output cla_pkg::gp_t         gp_o
);
  generate
    if (W == 1) begin : g_leaf
      assign gp_o   = gp_i[0];
      assign c_o[0] = c_i;
    end else begin : g_split
      localparam int H = W / 2;
      cla_pkg::gp_t lo_gp, hi_gp;
      logic         c_hi;

      cla_tree #(.W(H)) u_lo (
        .gp_i (gp_i[H-1:0]),
        .c_i  (c_i),
        .c_o  (c_o[H-1:0]),
        .gp_o (lo_gp)
      );

      cla_tree #(.W(H)) u_hi (
        .gp_i (gp_i[W-1:H]),
        .c_i  (c_hi),
        .c_o  (c_o[W-1:H]),
        .gp_o (hi_gp)
      );

      cla_node u_node (
        .lo_i   (lo_gp),
        .hi_i   (hi_gp),
        .c_i    (c_i),
        .blk_o  (gp_o),
        .c_hi_o (c_hi)
      );
    end
  endgenerate
endmodule

// File: rtl/cla_tree_adder.sv
module cla_tree_adder #(
  parameter int N = 16
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         c0_i,
  output logic [N-1:0] sum_o,
  output logic         g_o,
  output logic         p_o,
  output logic         carry_o
);
  // R8: width legality
  generate
    if (!cla_pkg::is_pow2(N)) begin : g_bad_width
      $error("cla_tree_adder: N must be a power of two >= 2");
    end
  endgenerate

  cla_pkg::gp_t [N-1:0] bit_gp;
  cla_pkg::gp_t         root_gp;
  logic [N-1:0]         bit_c;

  for (genvar i = 0; i < N; i++) begin : g_bit
    cla_bit_cell u_cell (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .gp_o (bit_gp[i])
    );
    assign sum_o[i] = bit_gp[i].p ^ bit_c[i];
  end

  cla_tree #(.W(N)) u_tree (
    .gp_i (bit_gp),
    .c_i  (c0_i),
    .c_o  (bit_c),
    .gp_o (root_gp)
  );

  assign g_o     = root_gp.g;
  assign p_o     = root_gp.p;
  assign carry_o = root_gp.g | (root_gp.p & c0_i);
endmodule

// File: rtl/cla_tree_adder_chk.sv
module cla_tree_adder_chk #(
  parameter int N = 16
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         c0_i,
  input logic [N-1:0] sum_o,
  input logic         g_o,
  input logic         p_o,
  input logic         carry_o
);
  logic [N:0] ref_full;
  logic [N:0] ref_nocin;
  logic       known;

  assign ref_full  = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, c0_i};
  assign ref_nocin = {1'b0, a_i} + {1'b0, b_i};
  assign known     = !$isunknown({a_i, b_i, c0_i, sum_o, g_o, p_o, carry_o});

  always_comb begin
    if (known) begin
      p_sum_match_r1: assert (sum_o == ref_full[N-1:0]);
      p_carry_match_r2: assert (carry_o == ref_full[N]);
      p_root_gen_r3: assert (g_o == ref_nocin[N]);
      p_root_prop_r4: assert (p_o == &(a_i ^ b_i));
      p_gp_exclusive_r5: assert (!(g_o && p_o));
      p_cout_form_r5: assert (carry_o == (g_o | (p_o & c0_i)));
      p_full_ripple_r6: assert (!(p_o && c0_i) || (sum_o == '0 && carry_o));
      p_low_cin_r7: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ c0_i));
    end
  end
endmodule

bind cla_tree_adder cla_tree_adder_chk #(.N(N)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .c0_i    (c0_i),
  .sum_o   (sum_o),
  .g_o     (g_o),
  .p_o     (p_o),
  .carry_o (carry_o)
);

// File: tb/cla_tree_adder_tb_top.sv
module cla_tree_adder_tb_top;
  localparam int  CLK_PERIOD = 10;
  localparam int  NB = 16;
  localparam int  NS = 4;
  localparam int  WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NB-1:0] a, b, sum;
  logic          c0, g, p, co;
  logic [NS-1:0] as, bs, sums;
  logic          c0s, gs, ps, cos;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  cla_tree_adder #(.N(NB)) dut_i (
    .a_i(a), .b_i(b), .c0_i(c0), .sum_o(sum), .g_o(g), .p_o(p), .carry_o(co)
  );

  cla_tree_adder #(.N(NS)) dut4_i (
    .a_i(as), .b_i(bs), .c0_i(c0s), .sum_o(sums), .g_o(gs), .p_o(ps), .carry_o(cos)
  );

  task automatic chk(string req, logic [NB:0] act, logic [NB:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h c0=%0b)", req, act, exp, a, b, c0);
    end
  endtask

  task automatic run_big(logic [NB-1:0] ta, logic [NB-1:0] tb_, logic tc);
    logic [NB:0] full, nocin;
    @(posedge clk);
    a = ta; b = tb_; c0 = tc;
    @(negedge clk);
    full  = {1'b0, ta} + {1'b0, tb_} + {{NB{1'b0}}, tc};
    nocin = {1'b0, ta} + {1'b0, tb_};
    chk("R1 sum", {1'b0, sum}, {1'b0, full[NB-1:0]});
    chk("R2 carry", {{NB{1'b0}}, co}, {{NB{1'b0}}, full[NB]});
    chk("R3 root_g", {{NB{1'b0}}, g}, {{NB{1'b0}}, nocin[NB]});
    chk("R4 root_p", {{NB{1'b0}}, p}, {{NB{1'b0}}, &(ta ^ tb_)});
    chk("R5 g_p_excl", {{NB{1'b0}}, g & p}, '0);
  endtask

  task automatic run_small(logic [NS-1:0] ta, logic [NS-1:0] tb_, logic tc);
    logic [NS:0] full;
    @(posedge clk);
    as = ta; bs = tb_; c0s = tc;
    @(negedge clk);
    full = {1'b0, ta} + {1'b0, tb_} + {{NS{1'b0}}, tc};
    chk("R1 sum4", {{(NB-NS){1'b0}}, 1'b0, sums}, {{(NB-NS){1'b0}}, 1'b0, full[NS-1:0]});
    chk("R2 carry4", {{NB{1'b0}}, cos}, {{NB{1'b0}}, full[NS]});
    chk("R5 cout_form4", {{NB{1'b0}}, cos}, {{NB{1'b0}}, gs | (ps & tc)});
  endtask

  initial begin
    a = '0; b = '0; c0 = 1'b0;
    as = '0; bs = '0; c0s = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    // zero inputs state
    chk("R1 zero_sum", {1'b0, sum}, '0);
    chk("R2 zero_carry", {{NB{1'b0}}, co}, '0);

    // R6: all-propagate with carry-in
    run_big('1, '0, 1'b1);
    chk("R6 ripple_sum", {1'b0, sum}, '0);
    chk("R6 ripple_carry", {{NB{1'b0}}, co}, 1);
    run_big(16'hA5A5, 16'h5A5A, 1'b1);
    chk("R6 ripple_mix", {co, sum}, {1'b1, {NB{1'b0}}});
    run_big(16'hA5A5, 16'h5A5A, 1'b0);

    // R7: all-generate
    for (int c = 0; c < 2; c++) begin
      run_big('1, '1, c[0]);
      chk("R7 gen_carry", {{NB{1'b0}}, co}, 1);
      chk("R7 gen_bit0", {{NB{1'b0}}, sum[0]}, {{NB{1'b0}}, c[0]});
    end

    // generate in a low half propagated through a high half
    run_big(16'h00FF, 16'hFF01, 1'b0);
    run_big(16'h0080, 16'h7F80, 1'b1);
    run_big(16'h8000, 16'h8000, 1'b0);

    for (int k = 0; k < 1500; k++) begin
      run_big(NB'($urandom), NB'($urandom), 1'($urandom));
    end

    // exhaustive sweep of the 4-bit configuration
    for (int x = 0; x < (1 << NS); x++)
      for (int y = 0; y < (1 << NS); y++)
        for (int c = 0; c < 2; c++)
          run_small(NS'(x), NS'(y), c[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end
endmodule